// File: doc/BRIEF.md
# Shared-Line Pixel Fire Decoder

This block works out which pixels of a small photodetector array fired during each counting interval of a frame, and when each one first fired. No pixel has a private output line. Each pixel instead pulls four shared lines high when it detects light: its row line, its column line, an up-diagonal line and a down-diagonal line. Each line is the wired-OR of every pixel attached to it. Once per counting interval, the block samples the whole line vector and marks as a candidate every pixel whose four lines are all high.

A pixel that did not fire can still appear as a candidate. This happens when its eight neighbours all fire in the same interval, because every one of its lines is then driven by a neighbour. The block keeps a three-interval window of candidate maps: the previous, the current and the next interval. It drops a surrounded candidate when the same pixel is also a candidate in an adjacent interval. The pixel then keeps the interval in which it shows up without the full surround. For each pixel, the block latches a fired bit and the index of its first confirmed interval.

A frame starts with a clear pulse. Its last interval is marked on the strobe that carries it. One further strobe supplies the look-ahead interval that is needed to judge the last interval. The frame result is complete when the done flag rises.

Top module: `pixel_fire_decoder`

## Requirements
- R1: For an array of ROWS by COLS pixels, the line vector has ROWS+COLS+2*(ROWS+COLS-1) bits. Pixel (r,c) drives these four lines: bit r (row), bit ROWS+c (column), bit ROWS+COLS+r+c (up-diagonal) and bit 2*ROWS+2*COLS-1+r-c+COLS-1 (down-diagonal).
- R2: A pixel is a candidate in an interval exactly when all four of its lines are high in that interval's sample. Several pixels firing together therefore produce the AND-of-wired-OR candidate set.
- R3: `fire_time[p*TW +: TW]` holds the 0-based interval index, counted from the clear, of the first interval in which pixel p = r*COLS+c has a confirmed fire, and `fired_map[p]` is then 1. Later fires of the same pixel in the same frame do not change either value.
- R4: A candidate in interval t is dropped when all eight of its neighbours are candidates in t and the pixel is also a candidate in interval t-1 or t+1.
- R5: A surrounded candidate with no candidate in the adjacent intervals is kept. A pixel on the array edge has fewer than eight neighbours and is never dropped.
- R6: `frame_done` rises on the edge that accepts the strobe following the strobe marked last. After that, strobes are ignored and the outputs hold.
- R7: A clear pulse zeroes `fired_map`, `fire_time`, `frame_done`, the interval count and the candidate history.
- R8: After reset, all outputs are zero. The outputs change only on an edge that accepts a strobe or applies a clear. Line values presented without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Starts a new frame; zeroes all frame state |
| samp_valid | input | 1 | Strobe: sample `bus_lines` as one interval |
| samp_last | input | 1 | Marks the strobed interval as the last one of the frame |
| bus_lines | input | NB | Shared line vector (NB = ROWS+COLS+2*(ROWS+COLS-1)) |
| fired_map | output | ROWS*COLS | One bit per pixel: a confirmed fire was seen in this frame |
| fire_time | output | ROWS*COLS*TW | Per-pixel interval index of the first confirmed fire |
| frame_done | output | 1 | The frame result is final |

## Verification
Two functions can act on one pixel in the same judged interval: ghost clearing of a surrounded candidate, and the first-fire latch of that pixel. The bench provokes this by firing a 3x3 block in one interval and only its centre in the next interval. A correct design stamps the centre with the later interval, and a missing clear shows up as the earlier index. The bench also fires the centre first and then again later, to show that a real earlier fire still wins. It checks that an edge pixel surrounded by the same pattern keeps its earlier stamp.

// File: rtl/trig_pkg.sv
// trig_pkg: line-vector layout shared by decoder and bench-facing docs.
// Assumes row lines first, then columns, then up-diagonals, then down-diagonals.
package trig_pkg;
    function automatic int bus_count(input int nr, input int nc);
        return nr + nc + 2 * (nr + nc - 1);
    endfunction

    function automatic int line_row(input int r);
        return r;
    endfunction

    function automatic int line_col(input int nr, input int c);
        return nr + c;
    endfunction

    function automatic int line_up(input int nr, input int nc, input int r, input int c);
        return nr + nc + r + c;
    endfunction

    function automatic int line_dn(input int nr, input int nc, input int r, input int c);
        return 2 * nr + 2 * nc - 1 + r - c + nc - 1;
    endfunction
endpackage

// File: rtl/fire_line_decode.sv
// fire_line_decode: combinational candidate map, one bit per pixel,
// high when all four shared lines of that pixel are high.
// Assumes the layout of trig_pkg; pixel index is r*COLS+c.
module fire_line_decode #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int NB   = trig_pkg::bus_count(ROWS, COLS),
    localparam int NPIX = ROWS * COLS
) (
    input  logic [NB-1:0]   lines,
    output logic [NPIX-1:0] cand
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            // AND of row, column and both diagonals for pixel (r,c)
            assign cand[r*COLS+c] = lines[trig_pkg::line_row(r)]
                                  & lines[trig_pkg::line_col(ROWS, c)]
                                  & lines[trig_pkg::line_up(ROWS, COLS, r, c)]
                                  & lines[trig_pkg::line_dn(ROWS, COLS, r, c)];
        end
    end
endmodule

// File: rtl/ghost_filter.sv
// ghost_filter: removes surrounded candidates that also appear in an
// adjacent interval. Edge pixels (fewer than eight neighbours) pass through.
module ghost_filter #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int NPIX = ROWS * COLS
) (
    input  logic [NPIX-1:0] cand_prev,
    input  logic [NPIX-1:0] cand_cur,
    input  logic [NPIX-1:0] cand_next,
    output logic [NPIX-1:0] confirmed
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int P = r * COLS + c;
            if (r > 0 && r < ROWS - 1 && c > 0 && c < COLS - 1) begin : g_inner
                logic ring;
                // all eight neighbours are candidates in the current interval
                assign ring = cand_cur[P-COLS-1] & cand_cur[P-COLS] & cand_cur[P-COLS+1]
                            & cand_cur[P-1]                          & cand_cur[P+1]
                            & cand_cur[P+COLS-1] & cand_cur[P+COLS] & cand_cur[P+COLS+1];
                // drop when surrounded and seen in a neighbouring interval
                assign confirmed[P] = cand_cur[P] & ~(ring & (cand_prev[P] | cand_next[P]));
            end else begin : g_edge
                assign confirmed[P] = cand_cur[P];
            end
        end
    end
endmodule

// File: rtl/first_fire_store.sv
// first_fire_store: per-pixel fired bit and first-interval stamp.
// Assumes wr_en pulses once per judged interval; only first write sticks.
module first_fire_store #(
    parameter int NPIX = 64,
    parameter int TW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [NPIX-1:0]  conf,
    input  logic [TW-1:0]    stamp_in,
    output logic [NPIX-1:0]  fired,
    output logic [NPIX*TW-1:0] stamps
);
    // latch the first confirmed interval of each pixel
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fired  <= '0;
            stamps <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NPIX; p++) begin
                if (conf[p] && !fired[p]) begin
                    fired[p]             <= 1'b1;
                    stamps[p*TW +: TW]   <= stamp_in;
                end
            end
        end
    end

    AST_FIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((fired & $past(fired)) == $past(fired))); // R3
endmodule

// File: rtl/pixel_fire_decoder.sv
// pixel_fire_decoder: top. Samples shared lines per strobe, keeps a
// three-interval candidate window, judges the middle interval and records
// first confirmed fires. Assumes a frame has at most 2**TW intervals and is
// followed by one look-ahead strobe.
module pixel_fire_decoder #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int TW   = 4,
    localparam int NB   = trig_pkg::bus_count(ROWS, COLS),
    localparam int NPIX = ROWS * COLS,
    localparam int IW   = TW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 samp_valid,
    input  logic                 samp_last,
    input  logic [NB-1:0]        bus_lines,
    output logic [NPIX-1:0]      fired_map,
    output logic [NPIX*TW-1:0]   fire_time,
    output logic                 frame_done
);
    logic [NPIX-1:0] cand_now, cand_prev_q, cand_cur_q, conf;
    logic [IW-1:0]   intv_q;
    logic [IW-1:0]   judged;
    logic            last_seen_q, done_q, accept;

    fire_line_decode #(.ROWS(ROWS), .COLS(COLS)) u_decode (
        .lines (bus_lines),
        .cand  (cand_now)
    );

    ghost_filter #(.ROWS(ROWS), .COLS(COLS)) u_filter (
        .cand_prev (cand_prev_q),
        .cand_cur  (cand_cur_q),
        .cand_next (cand_now),
        .confirmed (conf)
    );

    assign accept = samp_valid && !done_q && !clear;
    assign judged = intv_q - IW'(1);

    // shift the candidate window and advance the frame sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cand_prev_q <= '0;
            cand_cur_q  <= '0;
            intv_q      <= '0;
            last_seen_q <= 1'b0;
            done_q      <= 1'b0;
        end else if (accept) begin
            cand_prev_q <= cand_cur_q;
            cand_cur_q  <= cand_now;
            intv_q      <= intv_q + IW'(1);
            if (last_seen_q) done_q <= 1'b1;
            else if (samp_last) last_seen_q <= 1'b1;
        end
    end

    first_fire_store #(.NPIX(NPIX), .TW(TW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_en    (accept),
        .conf     (conf),
        .stamp_in (judged[TW-1:0]),
        .fired    (fired_map),
        .stamps   (fire_time)
    );

    assign frame_done = done_q;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fired_map == '0 && !frame_done)); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !clear) |=> (frame_done && $stable(fired_map) && $stable(fire_time))); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_valid && !clear) |=> ($stable(fired_map) && $stable(fire_time) && $stable(frame_done))); // R8
    AST_CONF_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((conf & ~cand_cur_q) == '0)); // R4
endmodule

// File: tb/pixel_fire_decoder_tb.sv
`timescale 1ns/1ps
module pixel_fire_decoder_tb;
    localparam int R  = 8;
    localparam int C  = 8;
    localparam int TW = 4;
    localparam int NB = R + C + 2 * (R + C - 1);
    localparam int NP = R * C;

    logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, samp_valid = 1'b0, samp_last = 1'b0;
    logic [NB-1:0] bus_lines = '0;
    logic [NP-1:0] fired_map;
    logic [NP*TW-1:0] fire_time;
    logic frame_done;
    int n_run = 0, n_fail = 0;
    logic [NP-1:0] fr [0:7];

    always #5 clk = ~clk;

    pixel_fire_decoder #(.ROWS(R), .COLS(C), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .samp_valid(samp_valid),
        .samp_last(samp_last), .bus_lines(bus_lines), .fired_map(fired_map),
        .fire_time(fire_time), .frame_done(frame_done));

    // R1 layout: lines driven by a set of firing pixels (wired-OR)
    function automatic logic [NB-1:0] lines_of(input logic [NP-1:0] m);
        logic [NB-1:0] v = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                if (m[r*C+c]) begin
                    v[r] = 1'b1; v[R+c] = 1'b1; v[R+C+r+c] = 1'b1;
                    v[2*R+2*C-1+r-c+C-1] = 1'b1;
                end
        return v;
    endfunction

    // R2: candidate set seen from a line vector
    function automatic logic [NP-1:0] cands_of(input logic [NB-1:0] v);
        logic [NP-1:0] m = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                m[r*C+c] = v[r] & v[R+c] & v[R+C+r+c] & v[2*R+2*C-1+r-c+C-1];
        return m;
    endfunction

    function automatic logic [NP-1:0] px(input int r, input int c);
        logic [NP-1:0] m = '0;
        m[r*C+c] = 1'b1;
        return m;
    endfunction

    function automatic logic [NP-1:0] block3(input int r, input int c);
        logic [NP-1:0] m = '0;
        for (int i = -1; i <= 1; i++)
            for (int j = -1; j <= 1; j++)
                if (r+i >= 0 && r+i < R && c+j >= 0 && c+j < C) m[(r+i)*C+c+j] = 1'b1;
        return m;
    endfunction

    task automatic chk_map(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s map act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_val(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int tm(input int p);
        return int'(fire_time[p*TW +: TW]);
    endfunction

    task automatic strobe(input logic [NB-1:0] v, input logic last);
        bus_lines = v; samp_last = last; samp_valid = 1'b1;
        @(negedge clk);
        samp_valid = 1'b0; samp_last = 1'b0; bus_lines = '0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // clear, n intervals from fr[], then look-ahead strobe
    task automatic run_frame(input int n);
        do_clear();
        for (int i = 0; i < n; i++) strobe(lines_of(fr[i]), i == n - 1);
        strobe('0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_map("R8 reset map", fired_map, '0);
        chk_val("R8 reset done", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3: every single pixel, at interval p%4 of a 4-interval frame
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < 8; i++) fr[i] = '0;
            fr[p % 4] = px(p / C, p % C);
            run_frame(4);
            chk_map("R1 single pixel", fired_map, px(p / C, p % C));
            chk_val("R3 single stamp", tm(p), p % 4);
            chk_val("R6 done", int'(frame_done), 1);
        end

        // R2: pairs firing together give the AND-of-wired-OR set
        for (int p = 0; p < NP; p++) begin
            logic [NP-1:0] pair;
            pair = px(p / C, p % C) | px(((p*7+3) % NP) / C, ((p*7+3) % NP) % C);
            for (int i = 0; i < 8; i++) fr[i] = '0;
            fr[0] = pair;
            run_frame(2);
            chk_map("R2 pair", fired_map, cands_of(lines_of(pair)));
        end

        // R4: block at t=1, centre alone at t=2 -> centre stamped 2
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[1] = block3(3, 3) & ~px(3, 3);
        fr[2] = px(3, 3);
        run_frame(4);
        chk_val("R4 ghost next interval", tm(3*C+3), 2);
        chk_val("R4 ring stamp", tm(2*C+2), 1);
        chk_map("R4 map", fired_map, block3(3, 3));

        // R4: block at t=2, centre again at t=3 -> centre stamped 3
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[2] = block3(4, 4);
        fr[3] = px(4, 4);
        run_frame(5);
        chk_val("R4 full block then centre", tm(4*C+4), 3);

        // R5: ring only -> ghost kept at t=1
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[1] = block3(3, 4) & ~px(3, 4);
        run_frame(3);
        chk_val("R5 lone ghost kept", tm(3*C+4), 1);
        chk_map("R5 map", fired_map, block3(3, 4));

        // R5: edge pixel (0,3) surrounded at t=1, fires t=2 -> stays 1
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[1] = block3(0, 3) & ~px(0, 3);
        fr[2] = px(0, 3);
        run_frame(4);
        chk_val("R5 edge not cleared", tm(3), 1);

        // R3: centre real fire at t=1 then block at t=3 -> stamp 1 held
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[1] = px(5, 5);
        fr[3] = block3(5, 5);
        run_frame(5);
        chk_val("R3 first fire wins", tm(5*C+5), 1);

        // R3: repeated fire keeps first stamp
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[1] = px(1, 2); fr[4] = px(1, 2);
        run_frame(6);
        chk_val("R3 later fire ignored", tm(1*C+2), 1);

        // R6/R8: done timing, ignored strobes, unstrobed lines
        do_clear();
        chk_val("R7 clear done", int'(frame_done), 0);
        chk_map("R7 clear map", fired_map, '0);
        strobe(lines_of(px(2, 6)), 1'b0);
        bus_lines = lines_of(px(6, 1));
        @(negedge clk);
        bus_lines = '0;
        strobe('0, 1'b1);
        chk_val("R6 not done before look-ahead", int'(frame_done), 0);
        strobe('0, 1'b0);
        chk_val("R6 done after look-ahead", int'(frame_done), 1);
        chk_map("R8 unstrobed lines ignored", fired_map, px(2, 6));
        strobe(lines_of(px(7, 7)), 1'b0);
        strobe(lines_of(px(7, 0)), 1'b0);
        chk_map("R6 strobes after done ignored", fired_map, px(2, 6));

        // R7: clear restarts the interval count at 0
        do_clear();
        chk_val("R7 clear stamps", int'(fire_time != '0), 0);
        for (int i = 0; i < 8; i++) fr[i] = '0;
        fr[0] = px(4, 0);
        run_frame(1);
        chk_val("R7 restart index", tm(4*C), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule